// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a fully associative translation buffer shared by instruction fetches and data accesses. It turns a 32-bit virtual address into a physical address in the same cycle. Each entry carries its own page-size code, so pages as small as 1KB and as large as 16MB can sit in the array at once. Every entry is searched in parallel, each under its own tag mask. A lookup also returns the page's cacheability and zone attributes, and it reports a miss, a permission fault or a multiple-match error.

Software owns replacement. It writes, reads back and invalidates entries through an index-addressed management port. Translation for instruction fetches and for data accesses is switched on separately. A side that is switched off passes its addresses through unchanged.

Top module: `vpTlbTop`

## Requirements
- R1: While `rstN` is low, every entry is made invalid. After reset, a management read of any index returns zero, and a translated lookup misses.
- R2: The management word is 63 bits. From the most significant bit down it holds: valid [62], size code [61:59], virtual page bits 31..10 [58:37], address-space tag [36:29], physical page bits 31..10 [28:7], writable [6], executable [5], cacheable [4], zone [3:0]. A write stores this word at `mgmtIdx` on the clock edge. From the next cycle, `mgmtRdData` returns the word held at `mgmtIdx`.
- R3: A translation placed at any index is found, and `rspIndex` reports that index on a hit.
- R4: For size code n (0..7), the low 10+2n address bits are the page offset. These bits are left out of the tag compare and are copied from the virtual to the physical address. The physical page bits fill the remaining upper bits.
- R5: Entries with different size codes translate correctly while they sit in the array together.
- R6: An entry matches only when its address-space tag equals `reqAsid`.
- R7: A translated lookup with no valid match raises `rspMiss` in the same cycle, with `rspHit` low and `rspPaddr` zero.
- R8: When several valid entries match, `rspMultiHit` is raised and the entry with the lowest index is used.
- R9: A data store to a page with writable clear, or an instruction fetch from a page with executable clear, raises `rspFault` with `rspHit` low and `rspPaddr` zero.
- R10: `instrXlatEn` and `dataXlatEn` act independently. On a disabled side, a lookup hits with `rspPaddr` equal to `reqVaddr`, cacheable 0 and zone 0, whatever the array holds.
- R11: `mgmtInvalAll` clears every valid bit and `mgmtInval` clears the one at `mgmtIdx`. The priority is invalidate-all, then invalidate-one, then write.
- R12: On a hit or a fault, `rspCacheable` and `rspZone` report the selected entry's attributes. With `reqValid` low, every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mgmtIdx | input | IDX_W | Entry index for management accesses |
| mgmtWrite | input | 1 | Write `mgmtWrData` to the indexed entry |
| mgmtInval | input | 1 | Clear the valid bit of the indexed entry |
| mgmtInvalAll | input | 1 | Clear every valid bit |
| mgmtWrData | input | 63 | Entry word to write |
| mgmtRdData | output | 63 | Entry word held at `mgmtIdx` |
| reqValid | input | 1 | A lookup is presented |
| reqInstr | input | 1 | Lookup is an instruction fetch |
| reqStore | input | 1 | Data lookup is a store |
| reqVaddr | input | 32 | Virtual address |
| reqAsid | input | 8 | Address-space tag of the requester |
| instrXlatEn | input | 1 | Translation enable for fetches |
| dataXlatEn | input | 1 | Translation enable for data accesses |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No valid entry matched |
| rspFault | output | 1 | Permission violation |
| rspMultiHit | output | 1 | More than one entry matched |
| rspPaddr | output | 32 | Physical address |
| rspCacheable | output | 1 | Page may be cached |
| rspZone | output | 4 | Protection zone of the page |
| rspIndex | output | IDX_W | Index of the entry used |

## Verification
The bench builds the block with `ENTRIES` = 8. With that size, the test can fill both ends of the index range, sweep every index through the read port, and place overlapping entries at a low and a high index. The page sizes tested reach the two extremes, 1KB and 16MB, plus 16KB and 256KB in between. These let the offset masking be checked at both edges of the address word. The default of 64 entries uses the same per-entry logic, generated more times.

// File: rtl/vpTlbPkg.sv
package vpTlbPkg;
  localparam int VADDR_W  = 32;
  localparam int MIN_OFF  = 10;
  localparam int PAGE_W   = VADDR_W - MIN_OFF;
  localparam int ASID_W   = 8;
  localparam int ZONE_W   = 4;
  localparam int SIZE_W   = 3;

  typedef struct packed {
    logic               valid;
    logic [SIZE_W-1:0]  sizeCode;
    logic [PAGE_W-1:0]  vPage;
    logic [ASID_W-1:0]  asid;
    logic [PAGE_W-1:0]  pPage;
    logic               writable;
    logic               executable;
    logic               cacheable;
    logic [ZONE_W-1:0]  zone;
  } tlbEntry_t;

  localparam int ENTRY_W = $bits(tlbEntry_t);

  typedef struct packed {
    logic               writable;
    logic               executable;
    logic               cacheable;
    logic [ZONE_W-1:0]  zone;
  } pageAttr_t;

  typedef struct packed {
    logic wr;
    logic invOne;
    logic invAll;
  } mgmtStrobe_t;

  function automatic logic [VADDR_W-1:0] offsetMask(input logic [SIZE_W-1:0] sc);
    return (VADDR_W'(1) << (MIN_OFF + 2 * int'(sc))) - VADDR_W'(1);
  endfunction
endpackage

// File: rtl/vpTlbDatapath.sv
module vpTlbDatapath
  import vpTlbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mgmtStrobe_t          strb,
  input  logic [IDX_W-1:0]     idx,
  input  tlbEntry_t            wrEntry,
  output tlbEntry_t            rdEntry,
  input  logic [VADDR_W-1:0]   vaddr,
  input  logic [ASID_W-1:0]    asid,
  output logic [ENTRIES-1:0]   matchVec,
  input  logic [IDX_W-1:0]     selIdx,
  output logic [VADDR_W-1:0]   selPaddr,
  output pageAttr_t            selAttr
);
  tlbEntry_t entries [ENTRIES];
  logic      idxOk;

  assign idxOk = 32'(idx) < ENTRIES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entries[i] <= '0;
    end else if (strb.invAll) begin
      for (int i = 0; i < ENTRIES; i++) entries[i].valid <= 1'b0;
    end else if (strb.invOne && idxOk) begin
      entries[idx].valid <= 1'b0;
    end else if (strb.wr && idxOk) begin
      entries[idx] <= wrEntry;
    end
  end

  assign rdEntry = idxOk ? entries[idx] : '0;

  // Parallel compare: each entry masks its own offset bits.
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [VADDR_W-1:0] keepMask;
    assign keepMask    = ~offsetMask(entries[g].sizeCode);
    assign matchVec[g] = entries[g].valid && (entries[g].asid == asid) &&
                         (((vaddr ^ {entries[g].vPage, {MIN_OFF{1'b0}}}) & keepMask) == '0);
  end

  logic [VADDR_W-1:0] selOff;
  assign selOff   = offsetMask(entries[selIdx].sizeCode);
  assign selPaddr = (vaddr & selOff) | ({entries[selIdx].pPage, {MIN_OFF{1'b0}}} & ~selOff);
  assign selAttr  = '{writable:   entries[selIdx].writable,
                      executable: entries[selIdx].executable,
                      cacheable:  entries[selIdx].cacheable,
                      zone:       entries[selIdx].zone};

  // R11: invalidate-all leaves no valid entry behind
  a_r11_inv_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.invAll |=> (matchVec == '0) && !rdEntry.valid);

  // R11: invalidate-one clears the addressed entry
  a_r11_inv_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invOne && !strb.invAll && idxOk) |=> !entries[$past(idx)].valid);

  // R2: a write lands at the addressed index
  a_r2_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && !strb.invOne && !strb.invAll && idxOk) |=> entries[$past(idx)] == $past(wrEntry));
endmodule

// File: rtl/vpTlbControl.sv
module vpTlbControl
  import vpTlbPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mgmtWrite,
  input  logic                 mgmtInval,
  input  logic                 mgmtInvalAll,
  output mgmtStrobe_t          strb,
  input  logic                 reqValid,
  input  logic                 reqInstr,
  input  logic                 reqStore,
  input  logic [VADDR_W-1:0]   reqVaddr,
  input  logic                 instrXlatEn,
  input  logic                 dataXlatEn,
  input  logic [ENTRIES-1:0]   matchVec,
  output logic [IDX_W-1:0]     selIdx,
  input  logic [VADDR_W-1:0]   selPaddr,
  input  pageAttr_t            selAttr,
  output logic                 rspHit,
  output logic                 rspMiss,
  output logic                 rspFault,
  output logic                 rspMultiHit,
  output logic [VADDR_W-1:0]   rspPaddr,
  output logic                 rspCacheable,
  output logic [ZONE_W-1:0]    rspZone,
  output logic [IDX_W-1:0]     rspIndex
);
  // Management decode: invalidate-all, then invalidate-one, then write.
  assign strb.invAll = mgmtInvalAll;
  assign strb.invOne = mgmtInval && !mgmtInvalAll;
  assign strb.wr     = mgmtWrite && !mgmtInval && !mgmtInvalAll;

  // Lowest-index match wins.
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) selIdx = IDX_W'(i);
  end

  logic anyMatch, several, xlatOn, permOk;
  assign anyMatch = |matchVec;
  assign several  = (matchVec & (matchVec - ENTRIES'(1))) != '0;
  assign xlatOn   = reqInstr ? instrXlatEn : dataXlatEn;
  assign permOk   = reqInstr ? selAttr.executable : (!reqStore || selAttr.writable);

  always_comb begin
    rspHit = 1'b0; rspMiss = 1'b0; rspFault = 1'b0; rspMultiHit = 1'b0;
    rspPaddr = '0; rspCacheable = 1'b0; rspZone = '0; rspIndex = '0;
    if (reqValid) begin
      if (!xlatOn) begin
        rspHit   = 1'b1;
        rspPaddr = reqVaddr;
      end else if (!anyMatch) begin
        rspMiss = 1'b1;
      end else begin
        rspMultiHit  = several;
        rspCacheable = selAttr.cacheable;
        rspZone      = selAttr.zone;
        rspIndex     = selIdx;
        if (permOk) begin
          rspHit   = 1'b1;
          rspPaddr = selPaddr;
        end else begin
          rspFault = 1'b1;
        end
      end
    end
  end

  // R7: a miss carries no translation
  a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (!rspHit && !rspFault && rspPaddr == '0 && matchVec == '0));

  // R9: a fault replaces the hit
  a_r9_fault_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (!rspHit && rspPaddr == '0));

  // R8: multi-hit only with a selected entry
  a_r8_multi_sel: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> ((rspHit || rspFault) && $countones(matchVec) > 1 && matchVec[rspIndex]));

  // R10: disabled side passes the address through
  a_r10_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqInstr ? instrXlatEn : dataXlatEn)) |-> (rspHit && rspPaddr == reqVaddr));

  // R12: idle request gives quiet outputs
  a_r12_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(rspHit || rspMiss || rspFault || rspMultiHit));
endmodule

// File: rtl/vpTlbTop.sv
module vpTlbTop
  import vpTlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W-1:0]   mgmtIdx,
  input  logic               mgmtWrite,
  input  logic               mgmtInval,
  input  logic               mgmtInvalAll,
  input  logic [62:0]        mgmtWrData,
  output logic [62:0]        mgmtRdData,
  input  logic               reqValid,
  input  logic               reqInstr,
  input  logic               reqStore,
  input  logic [31:0]        reqVaddr,
  input  logic [7:0]         reqAsid,
  input  logic               instrXlatEn,
  input  logic               dataXlatEn,
  output logic               rspHit,
  output logic               rspMiss,
  output logic               rspFault,
  output logic               rspMultiHit,
  output logic [31:0]        rspPaddr,
  output logic               rspCacheable,
  output logic [3:0]         rspZone,
  output logic [IDX_W-1:0]   rspIndex
);
  mgmtStrobe_t          strb;
  tlbEntry_t            rdEntry;
  logic [ENTRIES-1:0]   matchVec;
  logic [IDX_W-1:0]     selIdx;
  logic [VADDR_W-1:0]   selPaddr;
  pageAttr_t            selAttr;

  assign mgmtRdData = rdEntry;

  vpTlbDatapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(mgmtIdx),
    .wrEntry(tlbEntry_t'(mgmtWrData)), .rdEntry(rdEntry),
    .vaddr(reqVaddr), .asid(reqAsid), .matchVec(matchVec),
    .selIdx(selIdx), .selPaddr(selPaddr), .selAttr(selAttr)
  );

  vpTlbControl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .mgmtWrite(mgmtWrite), .mgmtInval(mgmtInval), .mgmtInvalAll(mgmtInvalAll),
    .strb(strb), .reqValid(reqValid), .reqInstr(reqInstr), .reqStore(reqStore),
    .reqVaddr(reqVaddr), .instrXlatEn(instrXlatEn), .dataXlatEn(dataXlatEn),
    .matchVec(matchVec), .selIdx(selIdx), .selPaddr(selPaddr), .selAttr(selAttr),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault), .rspMultiHit(rspMultiHit),
    .rspPaddr(rspPaddr), .rspCacheable(rspCacheable), .rspZone(rspZone),
    .rspIndex(rspIndex)
  );
endmodule

// File: tb/tb_vpTlbTop.sv
`timescale 1ns/1ps
module tb_vpTlbTop;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rstN = 1'b0;
  logic [IW-1:0] mgmtIdx = '0;
  logic mgmtWrite = 0, mgmtInval = 0, mgmtInvalAll = 0;
  logic [62:0] mgmtWrData = '0, mgmtRdData;
  logic reqValid = 0, reqInstr = 0, reqStore = 0;
  logic [31:0] reqVaddr = '0;
  logic [7:0] reqAsid = '0;
  logic instrXlatEn = 1, dataXlatEn = 1;
  logic rspHit, rspMiss, rspFault, rspMultiHit, rspCacheable;
  logic [31:0] rspPaddr;
  logic [3:0] rspZone;
  logic [IW-1:0] rspIndex;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vpTlbTop #(.ENTRIES(N)) dut (.*);

  typedef struct packed {
    logic instr; logic store; logic [7:0] asid; logic [31:0] va;
    logic [1:0] code; logic [31:0] pa; logic [3:0] zone; logic cach;
  } vec_t;

  // code: 0 hit, 1 miss, 2 fault
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 8'd5, 32'h0000_4123, 2'd0, 32'h8000_0123, 4'd1, 1'b1},
    '{1'b0, 1'b0, 8'd5, 32'h0000_4523, 2'd1, 32'h0,        4'd0, 1'b0},
    '{1'b0, 1'b1, 8'd5, 32'h0000_43FF, 2'd0, 32'h8000_03FF, 4'd1, 1'b1},
    '{1'b0, 1'b0, 8'd5, 32'h0010_3ABC, 2'd0, 32'h0020_3ABC, 4'd2, 1'b0},
    '{1'b0, 1'b1, 8'd5, 32'h0010_0004, 2'd2, 32'h0,        4'd2, 1'b0},
    '{1'b1, 1'b0, 8'd5, 32'h0010_1000, 2'd0, 32'h0020_1000, 4'd2, 1'b0},
    '{1'b1, 1'b0, 8'd5, 32'h0000_4000, 2'd2, 32'h0,        4'd1, 1'b1},
    '{1'b0, 1'b0, 8'd5, 32'h40AB_CDEF, 2'd0, 32'h01AB_CDEF, 4'd3, 1'b1},
    '{1'b0, 1'b0, 8'd5, 32'h4100_0000, 2'd1, 32'h0,        4'd0, 1'b0},
    '{1'b0, 1'b0, 8'd5, 32'h0803_FFFF, 2'd1, 32'h0,        4'd0, 1'b0},
    '{1'b0, 1'b0, 8'd9, 32'h0803_FFFF, 2'd0, 32'h0007_FFFF, 4'd4, 1'b0},
    '{1'b0, 1'b1, 8'd9, 32'h0804_0000, 2'd1, 32'h0,        4'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [62:0] mkEntry(input logic [2:0] sz, input logic [31:0] va,
      input logic [7:0] asid, input logic [31:0] pa, input logic w, input logic x,
      input logic c, input logic [3:0] z);
    return {1'b1, sz, va[31:10], asid, pa[31:10], w, x, c, z};
  endfunction

  task automatic mgmt(input logic [IW-1:0] idx, input logic wr, input logic inv,
                      input logic invAll, input logic [62:0] data);
    @(negedge clk);
    mgmtIdx = idx; mgmtWrite = wr; mgmtInval = inv; mgmtInvalAll = invAll; mgmtWrData = data;
    @(negedge clk);
    mgmtWrite = 0; mgmtInval = 0; mgmtInvalAll = 0;
  endtask

  task automatic look(input logic instr, input logic store, input logic [7:0] asid,
                      input logic [31:0] va);
    @(negedge clk);
    reqValid = 1; reqInstr = instr; reqStore = store; reqAsid = asid; reqVaddr = va;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      @(negedge clk); mgmtIdx = IW'(i); #1;
      chk("R1 read after reset", 64'(mgmtRdData), 64'h0);
    end
    look(0, 0, 8'd5, 32'h0000_4123);
    chk("R1 miss after reset", 64'({rspMiss, rspHit}), 64'b10);

    // fill entries at scattered indices with mixed sizes (R3, R5)
    mgmt(0, 1, 0, 0, mkEntry(3'd0, 32'h0000_4000, 8'd5, 32'h8000_0000, 1, 0, 1, 4'd1));
    mgmt(3, 1, 0, 0, mkEntry(3'd2, 32'h0010_0000, 8'd5, 32'h0020_0000, 0, 1, 0, 4'd2));
    mgmt(7, 1, 0, 0, mkEntry(3'd7, 32'h4000_0000, 8'd5, 32'h0100_0000, 1, 1, 1, 4'd3));
    mgmt(5, 1, 0, 0, mkEntry(3'd4, 32'h0800_0000, 8'd9, 32'h0004_0000, 1, 0, 0, 4'd4));
    @(negedge clk); mgmtIdx = 3; #1;
    chk("R2 readback", 64'(mgmtRdData),
        64'(mkEntry(3'd2, 32'h0010_0000, 8'd5, 32'h0020_0000, 0, 1, 0, 4'd2)));

    // table: R4 offsets, R5 mixed sizes, R6 asid, R7 miss, R9 faults, R12 attrs
    for (int v = 0; v < 12; v++) begin
      look(VECS[v].instr, VECS[v].store, VECS[v].asid, VECS[v].va);
      chk($sformatf("R7/R9 status vec%0d", v), 64'({rspHit, rspMiss, rspFault}),
          64'({VECS[v].code == 2'd0, VECS[v].code == 2'd1, VECS[v].code == 2'd2}));
      chk($sformatf("R4 paddr vec%0d", v), 64'(rspPaddr), 64'(VECS[v].pa));
      chk($sformatf("R12 attrs vec%0d", v), 64'({rspZone, rspCacheable}),
          64'({VECS[v].zone, VECS[v].cach}));
    end
    look(0, 0, 8'd9, 32'h0800_0010);
    chk("R3 index of match", 64'(rspIndex), 64'd5);

    // R10: independent enables
    @(negedge clk); instrXlatEn = 0;
    look(1, 0, 8'd5, 32'h0000_4000);
    chk("R10 fetch bypass", 64'({rspHit, rspPaddr, rspZone, rspCacheable}),
        64'({1'b1, 32'h0000_4000, 4'd0, 1'b0}));
    look(0, 0, 8'd5, 32'h0000_4123);
    chk("R10 data still translated", 64'(rspPaddr), 64'h8000_0123);
    @(negedge clk); instrXlatEn = 1; dataXlatEn = 0;
    look(0, 1, 8'd5, 32'h1234_5678);
    chk("R10 data bypass", 64'({rspHit, rspMiss, rspPaddr}), 64'({1'b1, 1'b0, 32'h1234_5678}));
    @(negedge clk); dataXlatEn = 1;

    // R8: overlapping entry at index 6
    mgmt(6, 1, 0, 0, mkEntry(3'd1, 32'h0000_4000, 8'd5, 32'h9000_0000, 1, 0, 0, 4'd6));
    look(0, 0, 8'd5, 32'h0000_4123);
    chk("R8 multi-hit lowest index", 64'({rspMultiHit, rspIndex, rspPaddr}),
        64'({1'b1, 3'd0, 32'h8000_0123}));

    // R11: invalidate one, with write asserted too (invalidate wins)
    mgmt(0, 1, 1, 0, mkEntry(3'd0, 32'h0000_4000, 8'd5, 32'hA000_0000, 1, 0, 1, 4'd1));
    look(0, 0, 8'd5, 32'h0000_4123);
    chk("R11 invalidate one", 64'({rspMultiHit, rspIndex, rspPaddr}),
        64'({1'b0, 3'd6, 32'h9000_0123}));

    // R11: invalidate all
    mgmt(2, 0, 0, 1, '0);
    look(0, 0, 8'd5, 32'h40AB_CDEF);
    chk("R11 invalidate all miss", 64'({rspHit, rspMiss}), 64'b01);
    @(negedge clk); mgmtIdx = 7; #1;
    chk("R11 valid cleared", 64'(mgmtRdData[62]), 64'd0);

    // R12: idle request
    @(negedge clk); reqValid = 0; #1;
    chk("R12 idle outputs", 64'({rspHit, rspMiss, rspFault, rspMultiHit, rspPaddr}), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule